// File: doc/BRIEF.md
# GPIO Port with Alternate-Function Override

An eight-pin bidirectional I/O port. Software reaches two byte registers over a simple register bus: an output latch and a direction register. Each pin's pad output enable and pad output value are worked out from those two registers, unless an alternate function takes the pin over.

Three kinds of alternate function can take over a pin, each switched on by an enable input from outside the block:

- Four PWM channels, one on each of pins 0 to 3.
- An event output on pin 6.
- A memory-ready input on pin 7. This takeover is honoured only in the expanded non-multiplexed and test operating modes.

A takeover never alters the stored direction bit. When the function is switched off, the pin returns to software control as it was left.

Reading the data offset always returns the sensed pad levels. Memory-ready is brought out as its own qualified output.

Top module: `gpio_ovr_port`

## Requirements
- R1: A synchronous active-high reset clears the output latch and the direction register to 0x00. With no enable asserted, every pad output enable is then 0.
- R2: A write to offset 0x33 loads the output latch on the next clock edge. On any pin that no alternate function drives, pad_out equals that pin's latch bit.
- R3: A write to offset 0x34 loads the direction register on the next clock edge, and a read of 0x34 returns it. On a pin that no function takes over, a direction bit of 1 sets pad_oe (output) and 0 clears it (input).
- R4: pwm_en[k] forces pad_oe[k]=1 and pad_out[k]=pwm_val[k], for k from 0 to 3. The stored direction bit is not changed, and it controls the pin again once pwm_en[k] falls.
- R5: evo_en forces pad_oe[6]=1 and pad_out[6]=evo_val, whatever direction bit 6 holds. Direction bit 6 keeps its stored value.
- R6: op_mode is encoded as 00 single-chip, 01 expanded non-multiplexed, 10 bootstrap and 11 test. With mrdy_en set in mode 01 or 11, pad_oe[7]=0 whatever direction bit 7 holds.
- R7: In modes 00 and 10, mrdy_en has no effect: pad_oe[7] follows direction bit 7 and mrdy_out stays 0.
- R8: Pins 4 and 5 are never taken over. Their pad_oe always equals direction bits 4 and 5.
- R9: A read of offset 0x33 returns pad_in, whatever the direction bits and the enables hold.
- R10: A read of any offset other than 0x33 and 0x34 returns 0x00. A write to such an offset changes neither register.
- R11: mrdy_out equals pad_in[7] while the memory-ready takeover is active (R6), and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 8 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| pwm_en | input | 4 | PWM channel enables for pins 0 to 3 |
| pwm_val | input | 4 | PWM channel levels |
| evo_en | input | 1 | Event output enable for pin 6 |
| evo_val | input | 1 | Event output level |
| mrdy_en | input | 1 | Memory-ready takeover request for pin 7 |
| op_mode | input | 2 | Operating mode |
| pad_in | input | 8 | Sensed pad levels |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output values |
| mrdy_out | output | 1 | Qualified memory-ready level |

## Verification
The latch is loaded with 0x5A and the direction register with mixed values such as 0xF0 and 0x0A. This separates pins whose value comes from the latch from pins whose enable comes from direction, and keeps a swapped bit or nibble visible.

The PWM enable pattern 0101 against a pwm_val of 0001 shows a forced pin's value next to a latch-driven neighbour. Restoring the direction register after the enables drop shows that the stored bit was never touched.

The memory-ready request is swept over all four modes with direction bit 7 set, which sets the two honouring modes apart from the two ignoring ones. Reads with every enable asserted, and writes to neighbouring unmapped offsets, separate the pad-level readback from the latch and from a decode that is off by one.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_EXPAND = 2'b01,
    MODE_BOOT   = 2'b10,
    MODE_TEST   = 2'b11
  } op_mode_e;

  // Memory-ready takeover is honoured only in expanded and test modes.
  function automatic logic mrdy_mode_ok(input logic [1:0] mode);
    return (mode == MODE_EXPAND) || (mode == MODE_TEST);
  endfunction

  // Resolve one pin: a takeover supplies both enable and value.
  function automatic logic [1:0] resolve_pin(input logic take, input logic alt_oe,
                                             input logic alt_val, input logic dir,
                                             input logic latch);
    return take ? {alt_oe, alt_val} : {dir, latch};
  endfunction

endpackage

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs #(
  parameter int ADDR_W   = 8,
  parameter int W        = 8,
  parameter int DATA_OFS = 'h33,
  parameter int DIR_OFS  = 'h34
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      latch_q,
  output logic [W-1:0]      dir_q
);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(DIR_OFS);

  logic hit_data, hit_dir;
  assign hit_data = wr && (addr == DATA_A);
  assign hit_dir  = wr && (addr == DIR_A);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      if (hit_data) latch_q <= wdata;
      if (hit_dir)  dir_q   <= wdata;
    end
  end
endmodule

// File: rtl/gpio_ovr_pinmux.sv
module gpio_ovr_pinmux
  import gpio_ovr_pkg::*;
#(
  parameter int W        = 8,
  parameter int PWM_N    = 4,
  parameter int EVO_PIN  = 6,
  parameter int MRDY_PIN = 7
) (
  input  logic [W-1:0]     latch_q,
  input  logic [W-1:0]     dir_q,
  input  logic [PWM_N-1:0] pwm_en,
  input  logic [PWM_N-1:0] pwm_val,
  input  logic             evo_en,
  input  logic             evo_val,
  input  logic             mrdy_act,
  output logic [W-1:0]     pad_oe,
  output logic [W-1:0]     pad_out
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [1:0] res;
    if (i < PWM_N) begin : g_pwm
      assign res = resolve_pin(pwm_en[i], 1'b1, pwm_val[i], dir_q[i], latch_q[i]);
    end else if (i == EVO_PIN) begin : g_evo
      assign res = resolve_pin(evo_en, 1'b1, evo_val, dir_q[i], latch_q[i]);
    end else if (i == MRDY_PIN) begin : g_mrdy
      assign res = resolve_pin(mrdy_act, 1'b0, latch_q[i], dir_q[i], latch_q[i]);
    end else begin : g_plain
      assign res = {dir_q[i], latch_q[i]};
    end
    assign pad_oe[i]  = res[1];
    assign pad_out[i] = res[0];
  end
endmodule

// File: rtl/gpio_ovr_rdmux.sv
module gpio_ovr_rdmux #(
  parameter int ADDR_W   = 8,
  parameter int W        = 8,
  parameter int DATA_OFS = 'h33,
  parameter int DIR_OFS  = 'h34
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      pad_in,
  input  logic [W-1:0]      dir_q,
  output logic [W-1:0]      rdata
);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(DIR_OFS);

  always_comb begin
    if (addr == DATA_A)      rdata = pad_in;
    else if (addr == DIR_A)  rdata = dir_q;
    else                     rdata = '0;
  end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int W        = 8,
  parameter int PWM_N    = 4,
  parameter int EVO_PIN  = 6,
  parameter int MRDY_PIN = 7,
  parameter int DATA_OFS = 'h33,
  parameter int DIR_OFS  = 'h34
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic [PWM_N-1:0]  pwm_en,
  input  logic [PWM_N-1:0]  pwm_val,
  input  logic              evo_en,
  input  logic              evo_val,
  input  logic              mrdy_en,
  input  logic [1:0]        op_mode,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_out,
  output logic              mrdy_out
);
  logic [W-1:0] latch_q, dir_q;
  logic         mrdy_act;

  assign mrdy_act = mrdy_en && mrdy_mode_ok(op_mode);
  assign mrdy_out = mrdy_act && pad_in[MRDY_PIN];

  gpio_ovr_regs #(.ADDR_W(ADDR_W), .W(W), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .latch_q(latch_q), .dir_q(dir_q)
  );

  gpio_ovr_pinmux #(.W(W), .PWM_N(PWM_N), .EVO_PIN(EVO_PIN), .MRDY_PIN(MRDY_PIN)) u_mux (
    .latch_q(latch_q), .dir_q(dir_q), .pwm_en(pwm_en), .pwm_val(pwm_val),
    .evo_en(evo_en), .evo_val(evo_val), .mrdy_act(mrdy_act),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  gpio_ovr_rdmux #(.ADDR_W(ADDR_W), .W(W), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)) u_rd (
    .addr(reg_addr), .pad_in(pad_in), .dir_q(dir_q), .rdata(reg_rdata)
  );
endmodule

// File: rtl/gpio_ovr_chk.sv
module gpio_ovr_chk #(
  parameter int ADDR_W   = 8,
  parameter int W        = 8,
  parameter int PWM_N    = 4,
  parameter int EVO_PIN  = 6,
  parameter int MRDY_PIN = 7,
  parameter int DATA_OFS = 'h33,
  parameter int DIR_OFS  = 'h34
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [W-1:0]      reg_wdata,
  input logic [W-1:0]      reg_rdata,
  input logic [PWM_N-1:0]  pwm_en,
  input logic [PWM_N-1:0]  pwm_val,
  input logic              evo_en,
  input logic              evo_val,
  input logic              mrdy_en,
  input logic [1:0]        op_mode,
  input logic [W-1:0]      pad_in,
  input logic [W-1:0]      pad_oe,
  input logic [W-1:0]      pad_out,
  input logic              mrdy_out,
  input logic [W-1:0]      latch_q,
  input logic [W-1:0]      dir_q
);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(DIR_OFS);

  logic mode_mr;
  assign mode_mr = (op_mode == 2'b01) || (op_mode == 2'b11);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (latch_q == '0) && (dir_q == '0));
  // R2
  data_write_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == DATA_A) |=> latch_q == $past(reg_wdata));
  // R3
  dir_write_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == DIR_A) |=> dir_q == $past(reg_wdata));
  // R10
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == DIR_A) |=> $stable(dir_q));
  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr != DATA_A && reg_addr != DIR_A) |-> reg_rdata == '0);
  // R4
  pwm_force_chk: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe[PWM_N-1:0] & pwm_en) == pwm_en) &&
    (((pad_out[PWM_N-1:0] ^ pwm_val) & pwm_en) == '0));
  // R5
  evo_force_chk: assert property (@(posedge clk) disable iff (rst)
    evo_en |-> pad_oe[EVO_PIN] && (pad_out[EVO_PIN] == evo_val));
  // R6
  mrdy_input_chk: assert property (@(posedge clk) disable iff (rst)
    (mrdy_en && mode_mr) |-> !pad_oe[MRDY_PIN]);
  // R7
  mrdy_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_mr |-> (pad_oe[MRDY_PIN] == dir_q[MRDY_PIN]) && !mrdy_out);
  // R8
  evin_dir_chk: assert property (@(posedge clk) disable iff (rst)
    pad_oe[5:4] == dir_q[5:4]);
  // R9
  rd_pins_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == DATA_A) |-> reg_rdata == pad_in);
  // R11
  mrdy_out_chk: assert property (@(posedge clk) disable iff (rst)
    mrdy_out |-> pad_in[MRDY_PIN] && mrdy_en && mode_mr);
endmodule

bind gpio_ovr_port gpio_ovr_chk #(
  .ADDR_W(ADDR_W), .W(W), .PWM_N(PWM_N), .EVO_PIN(EVO_PIN),
  .MRDY_PIN(MRDY_PIN), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)
) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .pwm_en(pwm_en), .pwm_val(pwm_val), .evo_en(evo_en),
  .evo_val(evo_val), .mrdy_en(mrdy_en), .op_mode(op_mode), .pad_in(pad_in),
  .pad_oe(pad_oe), .pad_out(pad_out), .mrdy_out(mrdy_out),
  .latch_q(latch_q), .dir_q(dir_q)
);

// File: tb/tb_gpio_ovr_port.sv
module tb_gpio_ovr_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_DATA = 8'h33;
  localparam logic [7:0] A_DIR  = 8'h34;

  logic       clk = 0, rst = 1, reg_wr = 0, evo_en = 0, evo_val = 0, mrdy_en = 0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00, pad_in = 8'h00;
  logic [3:0] pwm_en = 4'h0, pwm_val = 4'h0;
  logic [1:0] op_mode = 2'b00;
  logic [7:0] reg_rdata, pad_oe, pad_out;
  logic       mrdy_out;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ovr_port dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pwm_en(pwm_en), .pwm_val(pwm_val), .evo_en(evo_en),
    .evo_val(evo_val), .mrdy_en(mrdy_en), .op_mode(op_mode), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .mrdy_out(mrdy_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_addr = 8'h00;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
    reg_addr = 8'h00;
    #1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    pad_in = 8'hA5;
    settle();
    rd(A_DIR, v);  chk("R1 dir after reset", v, 8'h00);
    chk("R1 pad_oe after reset", pad_oe, 8'h00);
    chk("R1 pad_out after reset", pad_out, 8'h00);
  endtask

  task automatic t_data_dir();
    logic [7:0] v;
    wr(A_DIR, 8'hF0);
    wr(A_DATA, 8'h5A);
    chk("R3 pad_oe follows dir", pad_oe, 8'hF0);
    chk("R2 pad_out follows latch", pad_out, 8'h5A);
    rd(A_DIR, v); chk("R3 dir readback", v, 8'hF0);
  endtask

  task automatic t_pwm();
    logic [7:0] v;
    wr(A_DIR, 8'h00);
    pwm_en = 4'b0101; pwm_val = 4'b0001;
    settle();
    chk("R4 pwm oe", pad_oe, 8'h05);
    chk("R4 pwm out", pad_out, 8'h5B);
    rd(A_DIR, v); chk("R4 dir untouched", v, 8'h00);
    wr(A_DIR, 8'h0A);
    pwm_en = 4'hF; pwm_val = 4'h0;
    settle();
    chk("R4 all pwm oe", pad_oe, 8'h0F);
    chk("R4 all pwm out", pad_out, 8'h50);
    pwm_en = 4'h0;
    settle();
    chk("R4 dir restored", pad_oe, 8'h0A);
  endtask

  task automatic t_evo();
    logic [7:0] v;
    wr(A_DIR, 8'h00);
    evo_en = 1; evo_val = 1;
    settle();
    chk("R5 evo oe", pad_oe, 8'h40);
    chk("R5 evo out high", {7'd0, pad_out[6]}, 8'h01);
    evo_val = 0;
    settle();
    chk("R5 evo out low", {7'd0, pad_out[6]}, 8'h00);
    rd(A_DIR, v); chk("R5 dir6 kept", v, 8'h00);
    evo_en = 0;
    settle();
    chk("R5 evo released", pad_oe, 8'h00);
  endtask

  task automatic t_mrdy();
    wr(A_DIR, 8'h80);
    pad_in = 8'h80; mrdy_en = 1;
    for (int m = 0; m < 4; m++) begin
      logic honour;
      op_mode = 2'(m);
      honour = (m == 1) || (m == 3);
      settle();
      chk(honour ? "R6 mrdy oe7" : "R7 mrdy ignored oe7", {7'd0, pad_oe[7]}, {7'd0, !honour});
      chk(honour ? "R11 mrdy_out active" : "R7 mrdy_out blocked", {7'd0, mrdy_out}, {7'd0, honour});
    end
    pad_in = 8'h00; op_mode = 2'b11;
    settle();
    chk("R11 mrdy_out low pin", {7'd0, mrdy_out}, 8'h00);
    mrdy_en = 0; pad_in = 8'h80; op_mode = 2'b01;
    settle();
    chk("R11 mrdy_out without enable", {7'd0, mrdy_out}, 8'h00);
    chk("R6 pin7 back to dir", {7'd0, pad_oe[7]}, 8'h01);
  endtask

  task automatic t_evin();
    wr(A_DIR, 8'h30);
    pwm_en = 4'hF; evo_en = 1; mrdy_en = 1; op_mode = 2'b11;
    settle();
    chk("R8 ev-in pins output", {6'd0, pad_oe[5:4]}, 8'h03);
    wr(A_DIR, 8'h00);
    chk("R8 ev-in pins input", {6'd0, pad_oe[5:4]}, 8'h00);
  endtask

  task automatic t_read();
    logic [7:0] v;
    wr(A_DIR, 8'hFF);
    pad_in = 8'h3C;
    settle();
    rd(A_DATA, v); chk("R9 pin read with all enables", v, 8'h3C);
    pwm_en = 4'h0; evo_en = 0; mrdy_en = 0; pad_in = 8'hC3;
    settle();
    rd(A_DATA, v); chk("R9 pin read plain", v, 8'hC3);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    wr(A_DIR, 8'h0F);
    wr(A_DATA, 8'h00);
    wr(8'h35, 8'hFF);
    wr(8'h32, 8'hFF);
    rd(A_DIR, v); chk("R10 dir unchanged", v, 8'h0F);
    chk("R10 latch unchanged", pad_out, 8'h00);
    rd(8'h35, v); chk("R10 read 0x35", v, 8'h00);
    rd(8'h32, v); chk("R10 read 0x32", v, 8'h00);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_data_dir();
    t_pwm();
    t_evo();
    t_mrdy();
    t_evin();
    t_read();
    t_unmapped();
    report();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end
endmodule